// File: doc/BRIEF.md
# Flag-Coupled Integer ALU

This block is the arithmetic slice of a small processor core for the operations that both use and produce a one-bit status flag. The flag goes in with each operation as a carry or borrow and comes back out as the new carry, borrow or overflow. Each operation takes two W-bit operands, A and B, and the incoming flag. Its result and the new flag are registered together on the clock edge where the valid strobe is sampled high.

The operation set covers several cases. Addition and subtraction can chain through the flag for multi-word arithmetic. Addition and subtraction can also report signed overflow instead. Negation with borrow supports multi-word two's-complement negation. Two rotates move the operand one place through the flag, in either direction.

The register file, instruction decode and any other status bits are outside the block. The surrounding core supplies the operands and the flag, and takes the registered outputs back.

Top module: `tbit_alu`

## Requirements
- R1: A synchronous active-high reset clears the registered result and the registered flag to 0. Both read 0 one clock edge after reset is sampled high.
- R2: Operation code 0 (add with carry) registers B + A + T modulo 2^W. The new flag is 1 when either the sum B + A or the addition of T carries out of W bits.
- R3: Operation code 1 (add with overflow) registers B + A and ignores the incoming flag. The new flag is 1 only when A and B have equal sign bits (bit W-1) and the sum's sign bit differs from them.
- R4: Operation code 2 (subtract with borrow) registers B - A - T modulo 2^W. The new flag is 1 when B - A borrows or when the further subtraction of T borrows, that is, when A + T > B as unsigned values.
- R5: Operation code 3 (subtract with overflow) registers B - A and ignores the incoming flag. The new flag is 1 only when the sign bits of A and B differ and the difference's sign bit differs from that of B.
- R6: Operation code 4 (negate with borrow) registers 0 - A - T modulo 2^W and ignores B. The new flag is 0 only when A is 0 and T is 0.
- R7: Operation code 5 (rotate left through flag) registers B shifted left by one with the old flag in bit 0. Bit W-1 of B becomes the new flag. A is ignored.
- R8: Operation code 6 (rotate right through flag) registers B shifted right by one with the old flag in bit W-1. Bit 0 of B becomes the new flag. A is ignored.
- R9: Operation code 7 is reserved. A strobe carrying it leaves both the result and the flag unchanged.
- R10: While the valid strobe is low, the result and the flag hold their values whatever the other inputs do.
- R11: Latency is one cycle. The outputs keep their old values until the clock edge that samples the strobe, and carry the new values right after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe: execute the selected operation on this edge |
| in_op | input | 3 | Operation code (0 to 6 used, 7 reserved) |
| opnd_a | input | W | Operand A (addend, subtrahend or negated value) |
| opnd_b | input | W | Operand B (augend, minuend or rotated value) |
| t_in | input | 1 | Incoming flag (carry, borrow or rotate-in bit) |
| res_out | output | W | Registered result |
| t_out | output | 1 | Registered new flag |

## Verification
Every operation writes both outputs on the edge after its strobe, so a wrong internal state shows at the ports in the next cycle. A bad carry-in polarity or a wrong operand inversion in the shared adder corrupts the flag on the wraparound cases, such as 0 - 0 - 1 and 0xFFFFFFFF + 0 + 1. An overflow rule that uses the wrong operand's sign shows up on mixed-sign subtraction. A strobe that is gated badly shows up as a result or flag that changes during idle cycles or under the reserved code. The same fault also appears as a value that arrives one cycle early or late around the strobe edge.

// File: rtl/tbit_alu_pkg.sv
package tbit_alu_pkg;

  // operation codes; code 7 is reserved and leaves state untouched
  typedef enum logic [2:0] {
    OP_ADD_CY = 3'd0,
    OP_ADD_OV = 3'd1,
    OP_SUB_BR = 3'd2,
    OP_SUB_OV = 3'd3,
    OP_NEG_BR = 3'd4,
    OP_ROT_L  = 3'd5,
    OP_ROT_R  = 3'd6,
    OP_RSVD   = 3'd7
  } tbit_op_e;

endpackage

// File: rtl/tbit_arith.sv
// Shared adder for the add, subtract and negate operations.
// Subtraction is B + ~A + cin. A borrow is the absence of a carry out.
module tbit_arith
  import tbit_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  tbit_op_e       op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           t,
  output logic [W-1:0]   res,
  output logic           t_next,
  output logic           hit
);

  localparam int MSB = W - 1;

  logic [W-1:0] x, y;
  logic         cin;
  logic         inv;
  logic [W:0]   sum;
  logic         ovf;

  always_comb begin
    x   = b;
    inv = 1'b0;
    cin = 1'b0;
    hit = 1'b1;
    unique case (op)
      OP_ADD_CY: begin inv = 1'b0; cin = t;    end
      OP_ADD_OV: begin inv = 1'b0; cin = 1'b0; end
      OP_SUB_BR: begin inv = 1'b1; cin = ~t;   end
      OP_SUB_OV: begin inv = 1'b1; cin = 1'b1; end
      OP_NEG_BR: begin inv = 1'b1; cin = ~t; x = '0; end
      default:   hit = 1'b0;
    endcase
  end

  assign y   = inv ? ~a : a;
  assign sum = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
  assign res = sum[MSB:0];

  // signed overflow of x + y: same input signs, different result sign
  assign ovf = (x[MSB] == y[MSB]) && (sum[MSB] != x[MSB]);

  always_comb begin
    unique case (op)
      OP_ADD_CY: t_next = sum[W];
      OP_SUB_BR,
      OP_NEG_BR: t_next = ~sum[W];
      OP_ADD_OV,
      OP_SUB_OV: t_next = ovf;
      default:   t_next = t;
    endcase
  end

endmodule

// File: rtl/tbit_rot.sv
// One-place rotate of B through the flag bit.
module tbit_rot
  import tbit_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  tbit_op_e       op,
  input  logic [W-1:0]   b,
  input  logic           t,
  output logic [W-1:0]   res,
  output logic           t_next,
  output logic           hit
);

  localparam int MSB = W - 1;

  always_comb begin
    res    = b;
    t_next = t;
    hit    = 1'b0;
    unique case (op)
      OP_ROT_L: begin
        res    = {b[MSB-1:0], t};
        t_next = b[MSB];
        hit    = 1'b1;
      end
      OP_ROT_R: begin
        res    = {t, b[MSB:1]};
        t_next = b[0];
        hit    = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/tbit_alu.sv
module tbit_alu
  import tbit_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [2:0]     in_op,
  input  logic [W-1:0]   opnd_a,
  input  logic [W-1:0]   opnd_b,
  input  logic           t_in,
  output logic [W-1:0]   res_out,
  output logic           t_out
);

  tbit_op_e     op;
  logic [W-1:0] ar_res, rt_res;
  logic         ar_t, rt_t;
  logic         ar_hit, rt_hit;
  logic [W-1:0] res_d;
  logic         t_d;
  logic         load;

  assign op = tbit_op_e'(in_op);

  tbit_arith #(.W(W)) u_arith (
    .op     (op),
    .a      (opnd_a),
    .b      (opnd_b),
    .t      (t_in),
    .res    (ar_res),
    .t_next (ar_t),
    .hit    (ar_hit)
  );

  tbit_rot #(.W(W)) u_rot (
    .op     (op),
    .b      (opnd_b),
    .t      (t_in),
    .res    (rt_res),
    .t_next (rt_t),
    .hit    (rt_hit)
  );

  assign res_d = ar_hit ? ar_res : rt_res;
  assign t_d   = ar_hit ? ar_t   : rt_t;
  assign load  = in_valid && (ar_hit || rt_hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_out <= '0;
      t_out   <= 1'b0;
    end else if (load) begin
      res_out <= res_d;
      t_out   <= t_d;
    end
  end

endmodule

// File: rtl/tbit_alu_chk.sv
module tbit_alu_chk
  import tbit_alu_pkg::*;
#(
  parameter int W = 32
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic [2:0]     in_op,
  input logic [W-1:0]   opnd_a,
  input logic [W-1:0]   opnd_b,
  input logic           t_in,
  input logic [W-1:0]   res_out,
  input logic           t_out
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (res_out == '0) && !t_out);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(res_out) && $stable(t_out));

  // R9
  rsvd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == OP_RSVD) |=> $stable(res_out) && $stable(t_out));

  // R2
  add_cy_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == OP_ADD_CY) |=>
      {t_out, res_out} == ({1'b0, $past(opnd_b)} + {1'b0, $past(opnd_a)}
                           + {{W{1'b0}}, $past(t_in)}));

  // R6
  neg_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == OP_NEG_BR) |=>
      t_out == (($past(opnd_a) != '0) || $past(t_in)));

  // R7
  rot_l_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == OP_ROT_L) |=>
      res_out == {$past(opnd_b[W-2:0]), $past(t_in)} && t_out == $past(opnd_b[W-1]));

  // R8
  rot_r_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == OP_ROT_R) |=>
      res_out == {$past(t_in), $past(opnd_b[W-1:1])} && t_out == $past(opnd_b[0]));

endmodule

bind tbit_alu tbit_alu_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_op    (in_op),
  .opnd_a   (opnd_a),
  .opnd_b   (opnd_b),
  .t_in     (t_in),
  .res_out  (res_out),
  .t_out    (t_out)
);

// File: tb/sim_tbit_alu.sv
module sim_tbit_alu;

  localparam int W  = 32;
  localparam int NV = 19;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [2:0]   in_op = 3'd0;
  logic [W-1:0] opnd_a = '0;
  logic [W-1:0] opnd_b = '0;
  logic         t_in = 1'b0;
  logic [W-1:0] res_out;
  logic         t_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #10 clk = ~clk;  // 50 MHz

  tbit_alu #(.W(W)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .t_in(t_in),
    .res_out(res_out), .t_out(t_out)
  );

  // vector table: op, A, B, T in, expected result, expected flag, requirement
  localparam logic [2:0] V_OP [NV] = '{
    3'd0, 3'd0, 3'd0,            // R2
    3'd1, 3'd1, 3'd1,            // R3
    3'd2, 3'd2, 3'd2,            // R4
    3'd3, 3'd3, 3'd3,            // R5
    3'd4, 3'd4, 3'd4,            // R6
    3'd5, 3'd5,                  // R7
    3'd6, 3'd6                   // R8
  };
  localparam logic [W-1:0] V_A [NV] = '{
    32'h0000_0001, 32'h0000_0000, 32'h1234_5678,
    32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF,
    32'h0000_0001, 32'h0000_0000, 32'h0000_0005,
    32'h0000_0001, 32'hFFFF_FFFF, 32'h0000_0001,
    32'h0000_0000, 32'h0000_0000, 32'h0000_0001,
    32'hFFFF_FFFF, 32'h0000_0000,
    32'hFFFF_FFFF, 32'h0000_0000
  };
  localparam logic [W-1:0] V_B [NV] = '{
    32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h1111_1111,
    32'h0000_0001, 32'h8000_0000, 32'h0000_0001,
    32'h0000_0000, 32'h0000_0000, 32'h0000_0010,
    32'h8000_0000, 32'h7FFF_FFFF, 32'h0000_0005,
    32'hDEAD_BEEF, 32'h0000_0000, 32'h0000_0000,
    32'h8000_0001, 32'h4000_0000,
    32'h0000_0001, 32'h0000_0002
  };
  localparam logic V_T [NV] = '{
    1'b0, 1'b1, 1'b1,
    1'b1, 1'b0, 1'b1,
    1'b0, 1'b1, 1'b1,
    1'b0, 1'b0, 1'b1,
    1'b0, 1'b1, 1'b0,
    1'b0, 1'b1,
    1'b0, 1'b1
  };
  localparam logic [W-1:0] V_R [NV] = '{
    32'h0000_0000, 32'h0000_0000, 32'h2345_678A,
    32'h8000_0000, 32'h0000_0000, 32'h0000_0000,
    32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_000A,
    32'h7FFF_FFFF, 32'h8000_0000, 32'h0000_0004,
    32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
    32'h0000_0002, 32'h8000_0001,
    32'h0000_0000, 32'h8000_0001
  };
  localparam logic V_TO [NV] = '{
    1'b1, 1'b1, 1'b0,
    1'b1, 1'b1, 1'b0,
    1'b1, 1'b1, 1'b0,
    1'b1, 1'b1, 1'b0,
    1'b0, 1'b1, 1'b1,
    1'b1, 1'b0,
    1'b1, 1'b0
  };
  localparam string V_REQ [NV] = '{
    "R2", "R2", "R2", "R3", "R3", "R3", "R4", "R4", "R4",
    "R5", "R5", "R5", "R6", "R6", "R6", "R7", "R7", "R8", "R8"
  };

  task automatic check(input string req, input logic [W-1:0] act_r,
                       input logic act_t, input logic [W-1:0] exp_r,
                       input logic exp_t);
    n_chk++;
    if (act_r !== exp_r || act_t !== exp_t) begin
      n_bad++;
      $display("FAIL %s: result %h flag %b, expected result %h flag %b",
               req, act_r, act_t, exp_r, exp_t);
    end
  endtask

  // drive at a falling edge, strobe for one cycle, leave outputs to settle
  task automatic issue(input logic [2:0] op, input logic [W-1:0] a,
                       input logic [W-1:0] b, input logic t, input logic v);
    @(negedge clk);
    in_op = op; opnd_a = a; opnd_b = b; t_in = t; in_valid = v;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    logic [W-1:0] keep_r;
    logic         keep_t;

    // R1: reset state
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1", res_out, t_out, '0, 1'b0);

    // table walk, R2 through R8
    for (int i = 0; i < NV; i++) begin
      issue(V_OP[i], V_A[i], V_B[i], V_T[i], 1'b1);
      check(V_REQ[i], res_out, t_out, V_R[i], V_TO[i]);
    end

    // R10: strobe low with an operation that would change both outputs
    keep_r = res_out; keep_t = t_out;
    issue(3'd0, 32'hFFFF_FFFF, 32'h0000_0005, 1'b1, 1'b0);
    @(negedge clk);
    check("R10", res_out, t_out, keep_r, keep_t);

    // R9: reserved code with the strobe high
    issue(3'd2, 32'h0000_0001, 32'h0000_0000, 1'b0, 1'b1);  // FFFFFFFF, flag 1
    issue(3'd7, 32'h0000_0003, 32'h0000_0004, 1'b0, 1'b1);
    check("R9", res_out, t_out, 32'hFFFF_FFFF, 1'b1);

    // R11: old value just before the sampling edge, new value after it
    @(negedge clk);
    in_op = 3'd1; opnd_a = 32'h0000_0002; opnd_b = 32'h0000_0003;
    t_in = 1'b1; in_valid = 1'b1;
    #9;
    check("R11", res_out, t_out, 32'hFFFF_FFFF, 1'b1);
    @(negedge clk);
    in_valid = 1'b0;
    check("R11", res_out, t_out, 32'h0000_0005, 1'b0);

    // R3: the incoming flag has no effect on the overflow add
    issue(3'd1, 32'h0000_0002, 32'h0000_0003, 1'b0, 1'b1);
    check("R3", res_out, t_out, 32'h0000_0005, 1'b0);

    // R6: B has no effect on negate
    issue(3'd4, 32'h0000_0001, 32'h1234_5678, 1'b1, 1'b1);
    check("R6", res_out, t_out, 32'hFFFF_FFFE, 1'b1);

    // R4: chained two-word subtract 0x1_00000000 - 0x0_00000001
    issue(3'd2, 32'h0000_0001, 32'h0000_0000, 1'b0, 1'b1);
    check("R4", res_out, t_out, 32'hFFFF_FFFF, 1'b1);
    issue(3'd2, 32'h0000_0000, 32'h0000_0001, t_out, 1'b1);
    check("R4", res_out, t_out, 32'h0000_0000, 1'b0);

    // R1: reset in the middle of a run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1", res_out, t_out, '0, 1'b0);

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule